// File: doc/BRIEF.md
# Crossbar Bid Lane Controller

This block sits in a first-stage module of a three-stage buffered Clos fabric. It keeps a count of the cells waiting in each per-output-port queue. Each of its bid lanes faces one center-stage crossbar, and in every time slot each lane carries at most one bid. A bid names the destination queue and the service priority of one waiting cell. The cell leaves the pending count while it is on a lane, so no other lane can claim the same cell.

A new bid is picked in two levels. The highest-priority non-empty queue wins. Among queues of equal priority, a rotating pointer breaks the tie. Lanes pick in ascending lane order within a slot, and each pick moves the pointer just past the queue it chose.

Each crossbar answers its lane with a two-bit feedback code in the same slot as the bid.
- A win makes the lane strobe that cell out in the next slot, and the lane picks a fresh cell in that same slot.
- A lost contention makes the lane repeat the identical bid.
- A backpressure refusal puts the cell back in its queue, and the lane moves to another queue if one has cells.

One clock cycle is one time slot.

Top module: `bid_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, until the first cell arrives, no bid_valid_o and no tx_valid_o bit is high.
- R2: A cell that arrives at an idle block shows up as a bid on lane 0 in the second cycle after its arrival cycle.
- R3: A valid bid carries the index of its queue on bid_queue_o and that queue's priority from queue_prio_i on bid_prio_o.
- R4: Feedback code 01 (win) on a valid bid raises tx_valid_o for that lane in the next cycle, with tx_queue_o equal to the bid's queue. In that same cycle the lane shows a new bid if a pending cell exists. tx_valid_o is low in every other case.
- R5: Feedback code 10 (lost contention), and code 00 on a valid bid, make the lane hold the same bid, queue and priority unchanged, in the next cycle.
- R6: Feedback code 11 (backpressure) returns the cell to its queue. In the next cycle the lane bids on a different queue if any other queue holds a pending cell. Otherwise it bids on the refused queue again.
- R7: A lane that needs a new bid while no queue holds a pending cell drives bid_valid_o low for that lane.
- R8: Every arriving cell is eventually transmitted exactly once, and a cell is never on two lanes at once.
- R9: A new pick takes the highest-priority non-empty queue. Ties go to the first such queue at or after a rotating pointer. Lanes pick in ascending order within a cycle, and the pointer moves to one past each queue picked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per time slot |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arr_valid_i | input | 1 | A cell has arrived this cycle |
| arr_queue_i | input | QID_W | Destination queue of the arriving cell |
| queue_prio_i | input | NUM_QUEUES*PRIO_W | Service priority of each queue |
| fb_i | input | NUM_LANES*2 | Per-lane crossbar feedback: 00 none, 01 win, 10 lost, 11 backpressure |
| bid_valid_o | output | NUM_LANES | Lane carries a bid this cycle |
| bid_queue_o | output | NUM_LANES*QID_W | Destination queue of each bid |
| bid_prio_o | output | NUM_LANES*PRIO_W | Priority of each bid |
| tx_valid_o | output | NUM_LANES | Transmit strobe for a cell won in the previous cycle |
| tx_queue_o | output | NUM_LANES*QID_W | Queue of the transmitted cell |

## Verification
The hardest case to reach is a backpressure refusal while another queue still holds a waiting cell. Idle lanes normally grab any new cell one cycle after it arrives. The directed part therefore first fills all eight lanes from one queue and keeps every lane on lost-contention feedback. It then loads two other queues and refuses only lane 0, which must leave the refused queue. A long random phase follows, mixing arrivals with win, lost and backpressure codes, and a drain phase confirms that every cell leaves exactly once.

// File: rtl/bid_ctrl_pkg.sv
package bid_ctrl_pkg;
  typedef enum logic [1:0] {
    FB_NONE = 2'b00,
    FB_WIN  = 2'b01,
    FB_LOST = 2'b10,
    FB_BP   = 2'b11
  } fb_e;
endpackage

// File: rtl/bidc_pick.sv
module bidc_pick #(
  parameter int NUM_QUEUES = 40,
  parameter int CNT_W      = 6,
  parameter int PRIO_W     = 2,
  parameter int QID_W      = $clog2(NUM_QUEUES)
) (
  input  logic                                need_i,
  input  logic                                excl_v_i,
  input  logic [QID_W-1:0]                    excl_q_i,
  input  logic [NUM_QUEUES-1:0][CNT_W-1:0]    avail_i,
  input  logic [NUM_QUEUES-1:0][PRIO_W-1:0]   prio_i,
  input  logic [QID_W-1:0]                    ptr_i,
  output logic                                found_o,
  output logic [QID_W-1:0]                    q_o,
  output logic [NUM_QUEUES-1:0][CNT_W-1:0]    avail_o,
  output logic [QID_W-1:0]                    ptr_o
);
  logic [NUM_QUEUES-1:0] elig, alt, mask;
  logic [PRIO_W-1:0]     best;
  int                    idx;

  always_comb begin
    for (int q = 0; q < NUM_QUEUES; q++) begin
      elig[q] = (avail_i[q] != '0);
      alt[q]  = elig[q] && !(excl_v_i && (excl_q_i == QID_W'(q)));
    end
    // fall back to the refused queue only when nothing else is pending
    mask    = (alt != '0) ? alt : elig;
    found_o = 1'b0;
    q_o     = '0;
    best    = '0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      idx = int'(ptr_i) + i;
      if (idx >= NUM_QUEUES) idx = idx - NUM_QUEUES;
      if (mask[idx] && (!found_o || prio_i[idx] > best)) begin
        found_o = 1'b1;
        q_o     = QID_W'(idx);
        best    = prio_i[idx];
      end
    end
    if (!need_i) found_o = 1'b0;
    avail_o = avail_i;
    ptr_o   = ptr_i;
    if (found_o) begin
      avail_o[q_o] = avail_i[q_o] - CNT_W'(1);
      ptr_o = (q_o == QID_W'(NUM_QUEUES - 1)) ? '0 : q_o + QID_W'(1);
    end
  end
endmodule

// File: rtl/bidc_qcnt.sv
module bidc_qcnt #(
  parameter int NUM_QUEUES = 40,
  parameter int CNT_W      = 6,
  parameter int QID_W      = $clog2(NUM_QUEUES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_QUEUES-1:0][CNT_W-1:0] nxt_i,
  input  logic                             arr_valid_i,
  input  logic [QID_W-1:0]                 arr_queue_i,
  output logic [NUM_QUEUES-1:0][CNT_W-1:0] cnt_o
);
  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q
    logic hit;
    assign hit = arr_valid_i && (arr_queue_i == QID_W'(q));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_o[q] <= '0;
      else         cnt_o[q] <= nxt_i[q] + CNT_W'(hit);
    end
  end
endmodule

// File: rtl/bid_ctrl.sv
module bid_ctrl
  import bid_ctrl_pkg::*;
#(
  parameter int NUM_LANES  = 8,
  parameter int NUM_QUEUES = 40,
  parameter int PRIO_W     = 2,
  parameter int CNT_W      = 6,
  parameter int QID_W      = $clog2(NUM_QUEUES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              arr_valid_i,
  input  logic [QID_W-1:0]                  arr_queue_i,
  input  logic [NUM_QUEUES-1:0][PRIO_W-1:0] queue_prio_i,
  input  logic [NUM_LANES-1:0][1:0]         fb_i,
  output logic [NUM_LANES-1:0]              bid_valid_o,
  output logic [NUM_LANES-1:0][QID_W-1:0]   bid_queue_o,
  output logic [NUM_LANES-1:0][PRIO_W-1:0]  bid_prio_o,
  output logic [NUM_LANES-1:0]              tx_valid_o,
  output logic [NUM_LANES-1:0][QID_W-1:0]   tx_queue_o
);
  typedef logic [NUM_QUEUES-1:0][CNT_W-1:0] cnt_vec_t;

  cnt_vec_t         cnt, avail0;
  cnt_vec_t         avail_s [NUM_LANES+1];
  logic [QID_W-1:0] ptr_s   [NUM_LANES+1];
  logic [QID_W-1:0] rr_q;

  // cells refused by backpressure go back to their queue before picking
  always_comb begin
    avail0 = cnt;
    for (int k = 0; k < NUM_LANES; k++)
      if (bid_valid_o[k] && fb_i[k] == FB_BP)
        avail0[bid_queue_o[k]] = avail0[bid_queue_o[k]] + CNT_W'(1);
  end

  assign avail_s[0] = avail0;
  assign ptr_s[0]   = rr_q;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic             win, refused, need, found;
    logic [QID_W-1:0] pick_q;

    assign win     = bid_valid_o[k] && (fb_i[k] == FB_WIN);
    assign refused = bid_valid_o[k] && (fb_i[k] == FB_BP);
    assign need    = !bid_valid_o[k] || win || refused;

    bidc_pick #(
      .NUM_QUEUES(NUM_QUEUES), .CNT_W(CNT_W), .PRIO_W(PRIO_W), .QID_W(QID_W)
    ) u_pick (
      .need_i  (need),
      .excl_v_i(refused),
      .excl_q_i(bid_queue_o[k]),
      .avail_i (avail_s[k]),
      .prio_i  (queue_prio_i),
      .ptr_i   (ptr_s[k]),
      .found_o (found),
      .q_o     (pick_q),
      .avail_o (avail_s[k+1]),
      .ptr_o   (ptr_s[k+1])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bid_valid_o[k] <= 1'b0;
        bid_queue_o[k] <= '0;
        bid_prio_o[k]  <= '0;
        tx_valid_o[k]  <= 1'b0;
        tx_queue_o[k]  <= '0;
      end else begin
        tx_valid_o[k] <= win;
        tx_queue_o[k] <= bid_queue_o[k];
        if (need) begin
          bid_valid_o[k] <= found;
          bid_queue_o[k] <= pick_q;
          bid_prio_o[k]  <= queue_prio_i[pick_q];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else         rr_q <= ptr_s[NUM_LANES];
  end

  bidc_qcnt #(
    .NUM_QUEUES(NUM_QUEUES), .CNT_W(CNT_W), .QID_W(QID_W)
  ) u_qcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nxt_i      (avail_s[NUM_LANES]),
    .arr_valid_i(arr_valid_i),
    .arr_queue_i(arr_queue_i),
    .cnt_o      (cnt)
  );
endmodule

// File: rtl/bid_ctrl_chk.sv
module bid_ctrl_chk
  import bid_ctrl_pkg::*;
#(
  parameter int NUM_LANES  = 8,
  parameter int NUM_QUEUES = 40,
  parameter int PRIO_W     = 2,
  parameter int QID_W      = $clog2(NUM_QUEUES)
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [NUM_QUEUES-1:0][PRIO_W-1:0] queue_prio_i,
  input logic [NUM_LANES-1:0][1:0]         fb_i,
  input logic [NUM_LANES-1:0]              bid_valid_o,
  input logic [NUM_LANES-1:0][QID_W-1:0]   bid_queue_o,
  input logic [NUM_LANES-1:0][PRIO_W-1:0]  bid_prio_o,
  input logic [NUM_LANES-1:0]              tx_valid_o,
  input logic [NUM_LANES-1:0][QID_W-1:0]   tx_queue_o
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_chk
    // R5
    hold_on_lost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bid_valid_o[k] && (fb_i[k] == FB_LOST)) |=>
        (bid_valid_o[k] && $stable(bid_queue_o[k]) && $stable(bid_prio_o[k])));
    // R4
    tx_after_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bid_valid_o[k] && (fb_i[k] == FB_WIN)) |=>
        (tx_valid_o[k] && tx_queue_o[k] == $past(bid_queue_o[k])));
    // R4
    no_tx_without_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bid_valid_o[k] && (fb_i[k] == FB_WIN)) |=> !tx_valid_o[k]);
    // R3
    bid_prio_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bid_valid_o[k] |-> (bid_prio_o[k] == queue_prio_i[bid_queue_o[k]]));
    // R9
    bid_queue_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bid_valid_o[k] |-> (int'(bid_queue_o[k]) < NUM_QUEUES));
  end
endmodule

bind bid_ctrl bid_ctrl_chk #(
  .NUM_LANES(NUM_LANES), .NUM_QUEUES(NUM_QUEUES), .PRIO_W(PRIO_W), .QID_W(QID_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .queue_prio_i(queue_prio_i),
  .fb_i        (fb_i),
  .bid_valid_o (bid_valid_o),
  .bid_queue_o (bid_queue_o),
  .bid_prio_o  (bid_prio_o),
  .tx_valid_o  (tx_valid_o),
  .tx_queue_o  (tx_queue_o)
);

// File: tb/bid_ctrl_test.sv
module bid_ctrl_test;
  localparam int NL = 8;
  localparam int NQ = 40;
  localparam int PW = 2;
  localparam int QW = $clog2(NQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arr_v = 1'b0;
  logic [QW-1:0] arr_q = '0;
  logic [NQ-1:0][PW-1:0] qprio;
  logic [NL-1:0][1:0] fb = '0;
  logic [NL-1:0] bid_v, tx_v;
  logic [NL-1:0][QW-1:0] bid_q, tx_q;
  logic [NL-1:0][PW-1:0] bid_p;

  always #4 clk = ~clk;

  bid_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .arr_valid_i(arr_v), .arr_queue_i(arr_q),
    .queue_prio_i(qprio), .fb_i(fb), .bid_valid_o(bid_v), .bid_queue_o(bid_q),
    .bid_prio_o(bid_p), .tx_valid_o(tx_v), .tx_queue_o(tx_q)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int mcnt [NQ];
  int mbv [NL], mbq [NL], mbp [NL], mtxv [NL], mtxq [NL], lfb [NL];
  int mrr = 0;
  int nfb [NL];
  int narv = 0, narq = 0;
  int arrived = 0, txseen = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int f);
    if (f == 1) return "R4";
    if (f == 2) return "R5";
    if (f == 3) return "R6";
    return "R9";
  endfunction

  // compare outputs against the model (called at a falling edge)
  task automatic compare();
    for (int k = 0; k < NL; k++) begin
      bit ok;
      ok = (bid_v[k] === (mbv[k] != 0));
      if (ok && mbv[k] != 0) ok = (int'(bid_q[k]) == mbq[k]) && (int'(bid_p[k]) == mbp[k]);
      check(ok, tag_of(lfb[k]), bid_v[k] ? int'(bid_q[k]) : -1, mbv[k] != 0 ? mbq[k] : -1);
      ok = (tx_v[k] === (mtxv[k] != 0));
      if (ok && mtxv[k] != 0) ok = (int'(tx_q[k]) == mtxq[k]);
      check(ok, "R4", tx_v[k] ? int'(tx_q[k]) : -1, mtxv[k] != 0 ? mtxq[k] : -1);
      if (tx_v[k]) txseen++;
    end
  endtask

  task automatic model_step();
    int av [NQ];
    int ptr;
    for (int q = 0; q < NQ; q++) av[q] = mcnt[q];
    for (int k = 0; k < NL; k++) if (mbv[k] != 0 && nfb[k] == 3) av[mbq[k]]++;
    ptr = mrr;
    for (int k = 0; k < NL; k++) begin
      bit hold, excl, any_alt, found;
      int best, sel;
      mtxv[k] = (mbv[k] != 0 && nfb[k] == 1);
      mtxq[k] = mbq[k];
      hold = (mbv[k] != 0) && (nfb[k] == 0 || nfb[k] == 2);
      if (!hold) begin
        excl = (mbv[k] != 0 && nfb[k] == 3);
        any_alt = 0;
        for (int q = 0; q < NQ; q++) if (av[q] > 0 && !(excl && q == mbq[k])) any_alt = 1;
        found = 0; best = -1; sel = 0;
        for (int i = 0; i < NQ; i++) begin
          int idx;
          idx = (ptr + i) % NQ;
          if (av[idx] > 0 && !(excl && any_alt && idx == mbq[k]) && int'(qprio[idx]) > best) begin
            best = int'(qprio[idx]); sel = idx; found = 1;
          end
        end
        mbv[k] = found;
        if (found) begin
          mbq[k] = sel; mbp[k] = int'(qprio[sel]);
          av[sel]--; ptr = (sel + 1) % NQ;
        end
      end
      lfb[k] = nfb[k];
    end
    for (int q = 0; q < NQ; q++) mcnt[q] = av[q];
    if (narv != 0) begin mcnt[narq]++; arrived++; end
    mrr = ptr;
  endtask

  // one slot: compare, drive, advance model, wait for the next falling edge
  task automatic cyc();
    compare();
    for (int k = 0; k < NL; k++) fb[k] = 2'(nfb[k]);
    arr_v = (narv != 0);
    arr_q = QW'(narq);
    model_step();
    @(negedge clk);
  endtask

  task automatic set_hold();
    for (int k = 0; k < NL; k++) nfb[k] = (mbv[k] != 0) ? 2 : 0;
    narv = 0;
  endtask

  function automatic int outstanding(input int q);
    int n = 0;
    for (int k = 0; k < NL; k++) if (mbv[k] != 0 && mbq[k] == q) n++;
    return n;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int q = 0; q < NQ; q++) begin qprio[q] = PW'($urandom); mcnt[q] = 0; end
    for (int k = 0; k < NL; k++) begin
      mbv[k] = 0; mbq[k] = 0; mbp[k] = 0; mtxv[k] = 0; mtxq[k] = 0; lfb[k] = 0; nfb[k] = 0;
    end
    repeat (3) @(negedge clk);
    check(bid_v == '0 && tx_v == '0, "R1", int'(bid_v), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bid_v == '0 && tx_v == '0, "R1", int'(bid_v), 0);

    // R2 single arrival
    set_hold(); narv = 1; narq = 5; cyc();
    set_hold(); cyc();
    check(bid_v == 8'h01 && bid_q[0] == QW'(5), "R2", int'(bid_q[0]), 5);
    check(bid_p[0] == qprio[5], "R3", int'(bid_p[0]), int'(qprio[5]));
    // R5 lost contention
    set_hold(); nfb[0] = 2; cyc();
    check(bid_v[0] && bid_q[0] == QW'(5), "R5", int'(bid_q[0]), 5);
    // R6 backpressure with no other cell
    set_hold(); nfb[0] = 3; cyc();
    check(bid_v[0] && bid_q[0] == QW'(5), "R6", int'(bid_q[0]), 5);
    // R4 win, R7 nothing left
    set_hold(); nfb[0] = 1; cyc();
    check(tx_v[0] && tx_q[0] == QW'(5), "R4", int'(tx_q[0]), 5);
    check(!bid_v[0], "R7", int'(bid_v[0]), 0);
    set_hold(); cyc();
    check(!tx_v[0], "R4", int'(tx_v[0]), 0);

    // fill all lanes from queue 20, then load queues 5 and 9
    for (int i = 0; i < NL; i++) begin set_hold(); narv = 1; narq = 20; cyc(); end
    set_hold(); narv = 1; narq = 5; cyc();
    set_hold(); narv = 1; narq = 9; cyc();
    set_hold(); cyc();
    check(bid_v == 8'hFF, "R8", int'(bid_v), 255);
    set_hold(); nfb[0] = 3; cyc();
    check(bid_v[0] && bid_q[0] != QW'(20), "R6", int'(bid_q[0]), -20);
    set_hold(); nfb[1] = 1; cyc();
    check(tx_v[1] && bid_v[1], "R4", int'({tx_v[1], bid_v[1]}), 3);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      for (int k = 0; k < NL; k++) begin
        int r;
        r = int'($urandom % 8);
        nfb[k] = (mbv[k] == 0) ? 0 : (r < 4) ? 1 : (r < 6) ? 2 : 3;
      end
      narv = 0;
      if ($urandom % 10 < 7) begin
        int q;
        q = int'($urandom % NQ);
        if (mcnt[q] + outstanding(q) < 20) begin narv = 1; narq = q; end
      end
      cyc();
    end

    // drain: always win
    for (int c = 0; c < 400; c++) begin
      for (int k = 0; k < NL; k++) nfb[k] = (mbv[k] != 0) ? 1 : 0;
      narv = 0;
      cyc();
    end
    compare();
    check(bid_v == '0, "R8", int'(bid_v), 0);
    check(txseen == arrived, "R8", txseen, arrived);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule